// File: doc/BRIEF.md
# Power-Management Event Status and Interrupt Router

This block watches six power-management event sources: three general-purpose wake pins, a USB interrupt, an active-low thermal pin and an internal SMI request. Each source is synchronized and edge-detected. Each detected event sets a sticky bit in an event status register. Software clears a bit by writing a 1 to it. Each latched bit then drives one of two level outputs. The first is a System Control Interrupt line, gated by a per-source enable and by one global enable. The second is a System Management Interrupt line, fed by a separate SMI status register.

Each wake pin has a direction bit and a divert bit. A pin set as an output cannot raise a status bit on the control-interrupt path. A pin with its divert bit set sends its events to the SMI status bit instead, whatever the enable bits hold. Software reaches all registers through a small register bus. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Register addresses are 0 for event status, 1 for event enable, 2 for pin configuration, 3 for global control and 4 for SMI status.

Top module: `pme_router`

## Requirements
- R1: After reset, every register reads 0 and both `sciOut` and `smiOut` are 0.
- R2: A rising edge on `smiReq`, `usbIrq` or `wakePin[i]` sets event status bit 4, 6 or 8+i, in that order. The bit appears three clock edges after the input changes. Holding the input at its new level, or returning it to its old level, does not set the bit again.
- R3: A falling edge on `thermN` sets event status bit 5. A rising edge on `thermN` sets nothing.
- R4: Writing 1 to an event status bit clears it. Writing 0 to a bit leaves it unchanged.
- R5: If an event and a clear of the same status bit fall on the same clock edge, the bit stays 1.
- R6: Only bits 4, 5, 6, 8, 9 and 10 of the event status and event enable registers hold data. Bit 0 of global control and bits 0 to 2 and 4 to 6 of pin configuration hold data. Every other bit, including status bit 7, reads 0 whatever was written.
- R7: `sciOut` is 1 exactly when global control bit 0 is 1 and at least one event status bit is 1 with its matching enable bit also 1.
- R8: For wake pin i, pin configuration bit i is the direction, where 1 means output. While it is 1 and divert bit 4+i is 0, an edge on the pin leaves the event status unchanged.
- R9: While divert bit 4+i is 1, an edge on wake pin i sets SMI status bit 0 and leaves event status bit 8+i at 0. `smiOut` follows SMI status bit 0. Writing 1 to SMI status bit 0 clears it.
- R10: An SMI status set and a clear of SMI status bit 0 on the same clock edge leave the bit at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr` |
| wakePin | input | 3 | Wake pins, rising-edge events |
| usbIrq | input | 1 | USB interrupt, rising-edge event |
| thermN | input | 1 | Active-low thermal pin, falling-edge event |
| smiReq | input | 1 | Internal SMI request, rising-edge event |
| sciOut | output | 1 | System Control Interrupt level |
| smiOut | output | 1 | System Management Interrupt level |

## Verification
The hardest cases to reach from the ports are the collisions in R5 and R10. In each, a clear write must land on the same clock edge where a new event sets the bit. The stimulus first latches the bit and removes the source. It then raises the source again and holds it through two edges of the synchronizer. The clear write is then timed for the third edge, so the write and the set arrive together. The bench sweeps every source against all enable and global-enable combinations. It also sweeps every wake pin through all four direction and divert settings.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int NUM_WAKE = 3;
  localparam int NUM_SRC  = 3 + NUM_WAKE;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PINCFG = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SMIST  = 3'd4;

  localparam int SMI_BIT   = 4;
  localparam int THERM_BIT = 5;
  localparam int USB_BIT   = 6;
  localparam int WAKE_BASE = 8;
  localparam int DIR_BASE  = 0;
  localparam int DIV_BASE  = 4;
  localparam int GEN_BIT   = 0;

  function automatic logic [DATA_W-1:0] statMask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[SMI_BIT]   = 1'b1;
    m[THERM_BIT] = 1'b1;
    m[USB_BIT]   = 1'b1;
    for (int i = 0; i < NUM_WAKE; i++) m[WAKE_BASE+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] cfgMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_WAKE; i++) begin
      m[DIR_BASE+i] = 1'b1;
      m[DIV_BASE+i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] STAT_MASK = statMask();
  localparam logic [DATA_W-1:0] CFG_MASK  = cfgMask();

  typedef struct packed {
    logic              wrStatus;
    logic              wrEnable;
    logic              wrPinCfg;
    logic              wrCtrl;
    logic              wrSmiSt;
    logic [DATA_W-1:0] data;
  } busStrobe_t;
endpackage

// File: rtl/pme_ctrl.sv
module pme_ctrl
  import pme_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] statusQ,
  input  logic [DATA_W-1:0] enableQ,
  input  logic [DATA_W-1:0] pinCfgQ,
  input  logic [DATA_W-1:0] ctrlQ,
  input  logic [DATA_W-1:0] smiStQ,
  output busStrobe_t        strb,
  output logic [DATA_W-1:0] busRdData
);
  always_comb begin
    strb.wrStatus = busWrEn && (busAddr == ADDR_STATUS);
    strb.wrEnable = busWrEn && (busAddr == ADDR_ENABLE);
    strb.wrPinCfg = busWrEn && (busAddr == ADDR_PINCFG);
    strb.wrCtrl   = busWrEn && (busAddr == ADDR_CTRL);
    strb.wrSmiSt  = busWrEn && (busAddr == ADDR_SMIST);
    strb.data     = busWrData;
  end

  always_comb begin
    case (busAddr)
      ADDR_STATUS: busRdData = statusQ;
      ADDR_ENABLE: busRdData = enableQ;
      ADDR_PINCFG: busRdData = pinCfgQ;
      ADDR_CTRL:   busRdData = ctrlQ;
      ADDR_SMIST:  busRdData = smiStQ;
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: rtl/pme_datapath.sv
module pme_datapath
  import pme_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strb,
  input  logic [NUM_WAKE-1:0] wakePin,
  input  logic                usbIrq,
  input  logic                thermN,
  input  logic                smiReq,
  output logic [DATA_W-1:0]   statusQ,
  output logic [DATA_W-1:0]   enableQ,
  output logic [DATA_W-1:0]   pinCfgQ,
  output logic [DATA_W-1:0]   ctrlQ,
  output logic [DATA_W-1:0]   smiStQ,
  output logic                sciOut,
  output logic                smiOut
);
  logic [NUM_SRC-1:0] rawSrc;
  logic [NUM_SRC-1:0] edgeSrc;
  logic [DATA_W-1:0]  setVec;
  logic [DATA_W-1:0]  clrVec;
  logic               smiSet;
  logic               smiClr;

  // thermal pin inverted so every source is detected on a rising edge
  assign rawSrc = {wakePin, usbIrq, ~thermN, smiReq};

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
      logic [SYNC_STAGES:0] pipe;
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[SYNC_STAGES-1:0], rawSrc[s]};
      end
      assign edgeSrc[s] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
    end
  endgenerate

  always_comb begin
    setVec            = '0;
    smiSet            = 1'b0;
    setVec[SMI_BIT]   = edgeSrc[0];
    setVec[THERM_BIT] = edgeSrc[1];
    setVec[USB_BIT]   = edgeSrc[2];
    for (int i = 0; i < NUM_WAKE; i++) begin
      setVec[WAKE_BASE+i] = edgeSrc[3+i] & ~pinCfgQ[DIV_BASE+i] & ~pinCfgQ[DIR_BASE+i];
      smiSet              = smiSet | (edgeSrc[3+i] & pinCfgQ[DIV_BASE+i]);
    end
  end

  assign clrVec = strb.wrStatus ? strb.data : '0;
  assign smiClr = strb.wrSmiSt & strb.data[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      pinCfgQ <= '0;
      ctrlQ   <= '0;
      smiStQ  <= '0;
    end else begin
      statusQ   <= ((statusQ & ~clrVec) | setVec) & STAT_MASK;
      smiStQ[0] <= (smiStQ[0] & ~smiClr) | smiSet;
      if (strb.wrEnable) enableQ <= strb.data & STAT_MASK;
      if (strb.wrPinCfg) pinCfgQ <= strb.data & CFG_MASK;
      if (strb.wrCtrl)   ctrlQ[GEN_BIT] <= strb.data[GEN_BIT];
    end
  end

  assign sciOut = ctrlQ[GEN_BIT] & (|(statusQ & enableQ));
  assign smiOut = |smiStQ;
endmodule

// File: rtl/pme_router.sv
module pme_router
  import pme_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_WAKE-1:0] wakePin,
  input  logic                usbIrq,
  input  logic                thermN,
  input  logic                smiReq,
  output logic                sciOut,
  output logic                smiOut
);
  busStrobe_t        strb;
  logic [DATA_W-1:0] statusQ, enableQ, pinCfgQ, ctrlQ, smiStQ;

  pme_ctrl u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .statusQ(statusQ), .enableQ(enableQ), .pinCfgQ(pinCfgQ),
    .ctrlQ(ctrlQ), .smiStQ(smiStQ), .strb(strb), .busRdData(busRdData)
  );

  pme_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wakePin(wakePin),
    .usbIrq(usbIrq), .thermN(thermN), .smiReq(smiReq),
    .statusQ(statusQ), .enableQ(enableQ), .pinCfgQ(pinCfgQ),
    .ctrlQ(ctrlQ), .smiStQ(smiStQ), .sciOut(sciOut), .smiOut(smiOut)
  );
endmodule

// File: rtl/pme_router_chk.sv
module pme_router_chk
  import pme_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [DATA_W-1:0]   busWrData,
  input logic [DATA_W-1:0]   statusQ,
  input logic [DATA_W-1:0]   enableQ,
  input logic [DATA_W-1:0]   pinCfgQ,
  input logic [DATA_W-1:0]   ctrlQ,
  input logic                sciOut,
  input logic                smiOut
);
  logic [DATA_W-1:0] keepVec;
  logic              smiClrWr;

  assign keepVec  = statusQ & ~((busWrEn && busAddr == ADDR_STATUS) ? busWrData : '0);
  assign smiClrWr = busWrEn && (busAddr == ADDR_SMIST) && busWrData[0];

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ | enableQ) & ~STAT_MASK) == '0);

  // R7
  sci_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[GEN_BIT] |-> !sciOut);

  // R4
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(keepVec)) == $past(keepVec)));

  // R10
  smi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smiOut && !smiClrWr) |=> smiOut);

  generate
    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_wake
      // R8
      wake_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(statusQ[WAKE_BASE+i]) |-> !$past(pinCfgQ[DIR_BASE+i]));
      // R9
      wake_div_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(statusQ[WAKE_BASE+i]) |-> !$past(pinCfgQ[DIV_BASE+i]));
    end
  endgenerate
endmodule

bind pme_router pme_router_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .statusQ(statusQ), .enableQ(enableQ),
  .pinCfgQ(pinCfgQ), .ctrlQ(ctrlQ), .sciOut(sciOut), .smiOut(smiOut)
);

// File: tb/pme_router_bench.sv
module pme_router_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [2:0]  wakePin = '0;
  logic        usbIrq = 1'b0;
  logic        thermN = 1'b1;
  logic        smiReq = 1'b0;
  logic        sciOut, smiOut;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  pme_router u_pme_router (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .wakePin(wakePin),
    .usbIrq(usbIrq), .thermN(thermN), .smiReq(smiReq),
    .sciOut(sciOut), .smiOut(smiOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // source index: 0 smiReq (bit 4), 1 thermN (bit 5), 2 usbIrq (bit 6), 3+i wakePin[i] (bit 8+i)
  function automatic int srcBit(input int idx);
    if (idx < 3) return 4 + idx;
    return 8 + idx - 3;
  endfunction

  task automatic srcDrive(input int idx, input logic active);
    case (idx)
      0: smiReq = active;
      1: thermN = ~active;
      2: usbIrq = active;
      default: wakePin[idx-3] = active;
    endcase
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [15:0] d);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] d);
    busAddr = a;
    #2 d = busRdData;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  logic [15:0] rd;

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      readReg(a[2:0], rd); check("R1 reset read", rd, 16'h0000);
    end
    check("R1 sciOut", {15'd0, sciOut}, 16'd0);
    check("R1 smiOut", {15'd0, smiOut}, 16'd0);

    // R6 unused bits
    doWrite(3'd1, 16'hFFFF); readReg(3'd1, rd); check("R6 enable mask", rd, 16'h0770);
    doWrite(3'd2, 16'hFFFF); readReg(3'd2, rd); check("R6 pincfg mask", rd, 16'h0077);
    doWrite(3'd3, 16'hFFFF); readReg(3'd3, rd); check("R6 ctrl mask", rd, 16'h0001);
    doWrite(3'd0, 16'hFFFF); readReg(3'd0, rd); check("R6 status write-only-clear", rd, 16'h0000);
    doWrite(3'd1, 16'h0000); doWrite(3'd2, 16'h0000); doWrite(3'd3, 16'h0000);

    // R2 R3 R4 R7 sweep over every source, enable and global enable
    for (int s = 0; s < 6; s++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic [15:0] bitv;
        logic en, gen;
        bitv = 16'h1 << srcBit(s);
        en = cfg[0]; gen = cfg[1];
        doWrite(3'd1, en ? bitv : 16'h0);
        doWrite(3'd3, {15'd0, gen});
        srcDrive(s, 1'b1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        readReg(3'd0, rd); check("R2 not before third edge", rd, 16'h0000);
        @(posedge clk); @(negedge clk);
        readReg(3'd0, rd); check(s == 1 ? "R3 falling edge sets" : "R2 edge sets", rd, bitv);
        check("R7 sci gating", {15'd0, sciOut}, {15'd0, en & gen});
        doWrite(3'd0, ~bitv); readReg(3'd0, rd); check("R4 write 0 keeps", rd, bitv);
        doWrite(3'd0, bitv);  readReg(3'd0, rd); check("R4 write 1 clears", rd, 16'h0000);
        check("R7 sci after clear", {15'd0, sciOut}, 16'd0);
        settle(); readReg(3'd0, rd); check("R2 held level no reset", rd, 16'h0000);
        srcDrive(s, 1'b0);
        settle(); settle();
        readReg(3'd0, rd); check(s == 1 ? "R3 rising edge ignored" : "R2 falling edge ignored", rd, 16'h0000);
      end
    end
    doWrite(3'd1, 16'h0000); doWrite(3'd3, 16'h0000);

    // R8 R9 wake pins over direction and divert settings
    for (int p = 0; p < 3; p++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic dir, dv;
        logic [15:0] expStat;
        dir = cfg[0]; dv = cfg[1];
        doWrite(3'd2, (16'(dir) << p) | (16'(dv) << (4 + p)));
        expStat = (!dir && !dv) ? (16'h0100 << p) : 16'h0000;
        srcDrive(3 + p, 1'b1);
        settle();
        readReg(3'd0, rd);
        check(dv ? "R9 divert keeps status 0" : "R8 direction gating", rd, expStat);
        readReg(3'd4, rd); check("R9 smi status", rd, {15'd0, dv});
        check("R9 smiOut", {15'd0, smiOut}, {15'd0, dv});
        doWrite(3'd4, 16'h0001); doWrite(3'd0, 16'hFFFF);
        check("R9 smiOut cleared", {15'd0, smiOut}, 16'd0);
        srcDrive(3 + p, 1'b0);
        settle();
      end
    end

    // R5 collision on usb bit
    srcDrive(2, 1'b1); settle(); srcDrive(2, 1'b0); settle();
    readReg(3'd0, rd); check("R5 setup", rd, 16'h0040);
    srcDrive(2, 1'b1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    busAddr = 3'd0; busWrEn = 1'b1; busWrData = 16'h0040;
    @(posedge clk); @(negedge clk); busWrEn = 1'b0;
    readReg(3'd0, rd); check("R5 set wins over clear", rd, 16'h0040);
    doWrite(3'd0, 16'h0040); readReg(3'd0, rd); check("R5 later clear", rd, 16'h0000);
    srcDrive(2, 1'b0); settle();

    // R10 collision on smi status via wake pin 1 with divert
    doWrite(3'd2, 16'h0020);
    srcDrive(4, 1'b1); settle(); srcDrive(4, 1'b0); settle();
    check("R10 setup", {15'd0, smiOut}, 16'd1);
    srcDrive(4, 1'b1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    busAddr = 3'd4; busWrEn = 1'b1; busWrData = 16'h0001;
    @(posedge clk); @(negedge clk); busWrEn = 1'b0;
    readReg(3'd4, rd); check("R10 set wins over clear", rd, 16'h0001);
    doWrite(3'd4, 16'h0001); readReg(3'd4, rd); check("R10 later clear", rd, 16'h0000);
    srcDrive(4, 1'b0); settle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule